// File: doc/BRIEF.md
# DSD Input Resynchronizer with Resync Mute

This block carries a one-bit DSD stream from the timing of its input bit clock into the timing of one or more output events. Everything runs on a single fast system clock. The clock edges arrive as one-cycle enable strobes: a rising and a falling strobe for the input bit clock, one event strobe for the DSD output path and one for the PCM word path. Each input bit is stored twice. One register takes it on the rising strobe and a second register takes it on the falling strobe. An output event reads one of these two registers and never the live input pin.

A rising edge on the sync level restarts the alignment. The next falling strobe of the input clock marks a phase reference. Each output path then fixes its choice of register at its own first event after that mark. The choice depends on which half of the input bit period that event falls in. A resync can drop or repeat one bit. To hide this, each path sends out an alternating idle pattern and raises a mute flag for a fixed number of its own events. On the PCM path a mode input selects that number.

Top module: `dsd_resync`

## Requirements
- R1: Register A loads `din` on `in_rise` and register B loads `din` on `in_fall`. An output bit is always taken from one of these registers, so a change on `din` between strobes never reaches an output.
- R2: After a rising edge of `sync_in`, the first following `in_fall` marks the phase reference. A path locks its choice at its first event on or after that strobe. If the most recent input strobe before the event was a fall, the path selects A and reads the bit that is currently in progress. If it was a rise, the path selects B and reads the previous bit.
- R3: Once locked, with one DSD event per input bit period and each event staying in the half-period where it locked, the unmuted DSD outputs follow the input bits in order, with no skip and no repeat.
- R4: `dsd_valid` and `pcm_valid` go high for exactly the one cycle after each event strobe of their path. The data and mute outputs of a path change only in that cycle.
- R5: After each rising edge of `sync_in`, the next 4 DSD-path events produce outputs with `dsd_mute` set. The next DSD output has `dsd_mute` clear.
- R6: After each rising edge of `sync_in`, the PCM path mutes a number of events set by `pcm_mode`, sampled at that edge: 34 for 2'b01, 18 for 2'b10, and 4 for 2'b00 or 2'b11.
- R7: While muted, a path outputs 0, 1, 0, 1, … on successive events, starting again with 0 after every sync edge.
- R8: A sync edge that arrives while a mute window is running reloads the full mute length and restarts the phase decision.
- R9: The PCM path locks independently from its own event timing. At a steady ratio of N input bits per PCM event, its unmuted outputs are every Nth input bit, counted from its lock point.
- R10: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | DSD input data |
| in_rise | input | 1 | Strobe for the input bit-clock rising edge |
| in_fall | input | 1 | Strobe for the input bit-clock falling edge |
| dsd_evt | input | 1 | Strobe for the DSD output bit-clock event |
| pcm_evt | input | 1 | Strobe for the PCM word-boundary event |
| sync_in | input | 1 | Sync/init level; its rising edge starts a resync |
| pcm_mode | input | 2 | Selects the PCM mute length |
| dsd_bit | output | 1 | DSD-path output bit |
| dsd_valid | output | 1 | One-cycle strobe when a DSD-path output is updated |
| dsd_mute | output | 1 | Mute flag for the current DSD-path output |
| pcm_bit | output | 1 | PCM-path output bit |
| pcm_valid | output | 1 | One-cycle strobe when a PCM-path output is updated |
| pcm_mute | output | 1 | Mute flag for the current PCM-path output |

## Verification
Each fault inside the block shows up at the ports within one output event:
- A wrong register choice or a slip in the capture shifts the output bit stream by one position. This breaks the order of unmuted bits at the first unmuted event after the lock.
- A wrong mute count moves the falling edge of the mute flag to a different event. This is visible at the 5th, 19th or 35th output after sync.
- A reload that goes missing during a running window ends the mute too early.
- A bad idle toggle makes the muted data break the 0,1 alternation.

The bench compares every output on every clock against a model built from event timestamps and a queue of input history. Any of these faults therefore fails at the first event where it differs.

// File: rtl/dsdrs_pkg.sv
package dsdrs_pkg;

  // Which capture register an output event reads
  typedef enum logic {
    SEL_A = 1'b0,   // loaded on the input rising strobe
    SEL_B = 1'b1    // loaded on the input falling strobe
  } bufsel_e;

  // Mute-length mode codes
  typedef enum logic [1:0] {
    SPAN_BIT  = 2'd0,
    SPAN_W8   = 2'd1,
    SPAN_W2   = 2'd2,
    SPAN_RSV  = 2'd3
  } span_mode_e;

  // Event late in the input period: A holds the running bit, safe to read.
  // Event early in the period: B is stable until the next fall.
  function automatic bufsel_e choose_buf(input logic in_second_half);
    return in_second_half ? SEL_A : SEL_B;
  endfunction

  function automatic int unsigned span_len(input logic [1:0] mode,
                                           input int unsigned bit_len,
                                           input int unsigned w8_len,
                                           input int unsigned w2_len);
    case (span_mode_e'(mode))
      SPAN_W8: return w8_len;
      SPAN_W2: return w2_len;
      default: return bit_len;
    endcase
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dsdrs_capture.sv
module dsdrs_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic in_rise,
  input  logic in_fall,
  input  logic sync_in,
  output logic buf_a,
  output logic buf_b,
  output logic second_half,
  output logic sync_rise,
  output logic phase_tick
);

  logic sync_q;
  logic armed;

  assign sync_rise  = sync_in & ~sync_q;
  assign phase_tick = armed & in_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q      <= 1'b0;
      buf_a       <= 1'b0;
      buf_b       <= 1'b0;
      second_half <= 1'b0;
      armed       <= 1'b0;
    end else begin
      sync_q <= sync_in;
      if (in_rise) buf_a <= din;
      if (in_fall) buf_b <= din;
      if (in_fall)      second_half <= 1'b1;
      else if (in_rise) second_half <= 1'b0;
      if (sync_rise)    armed <= 1'b1;
      else if (in_fall) armed <= 1'b0;
    end
  end

  // R2
  half_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rise && !in_fall) |=> !second_half);

  // R2
  half_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fall |=> second_half);

  // R8
  sync_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rise |=> armed);

  // R2
  tick_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_tick && !sync_rise) |=> !armed);

endmodule

// File: rtl/dsdrs_path.sv
module dsdrs_path
  import dsdrs_pkg::*;
#(
  parameter int unsigned BIT_LEN = 4,
  parameter int unsigned W8_LEN  = 34,
  parameter int unsigned W2_LEN  = 18,
  parameter int unsigned CNT_W   = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt,
  input  logic [1:0] mode,
  input  logic       buf_a,
  input  logic       buf_b,
  input  logic       second_half,
  input  logic       sync_rise,
  input  logic       phase_tick,
  output logic       out_bit,
  output logic       out_valid,
  output logic       out_mute
);

  logic [CNT_W-1:0] span;
  logic [CNT_W-1:0] cnt;
  logic             cnt_zero;
  logic             pending;
  bufsel_e          sel;
  bufsel_e          pick;
  logic             lock_now;
  logic             live_bit;
  logic             mute_now;
  logic             idle;

  assign span     = CNT_W'(span_len(mode, BIT_LEN, W8_LEN, W2_LEN));
  assign cnt_zero = (cnt == '0);
  assign lock_now = evt & (pending | phase_tick);
  assign pick     = lock_now ? choose_buf(second_half) : sel;
  assign live_bit = (pick == SEL_A) ? buf_a : buf_b;
  assign mute_now = sync_rise | ~cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      sel       <= SEL_A;
      cnt       <= '0;
      idle      <= 1'b0;
      out_bit   <= 1'b0;
      out_valid <= 1'b0;
      out_mute  <= 1'b0;
    end else begin
      if (sync_rise)       pending <= 1'b0;
      else if (lock_now)   pending <= 1'b0;
      else if (phase_tick) pending <= 1'b1;

      if (lock_now) sel <= pick;

      if (sync_rise)              cnt <= span;
      else if (evt && !cnt_zero)  cnt <= cnt - CNT_W'(1);

      if (sync_rise)             idle <= 1'b0;
      else if (evt && mute_now)  idle <= ~idle;

      out_valid <= evt;
      if (evt) begin
        out_bit  <= mute_now ? idle : live_bit;
        out_mute <= mute_now;
      end
    end
  end

  // R4
  mute_at_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_mute) |-> $past(evt));

  // R4
  bit_at_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_bit) |-> $past(evt));

  // R5
  mute_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rise |=> !cnt_zero);

  // R2
  lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_now && !sync_rise) |=> !pending);

endmodule

// File: rtl/dsd_resync.sv
module dsd_resync
  import dsdrs_pkg::*;
#(
  parameter int unsigned BIT_MUTE = 4,
  parameter int unsigned W8_MUTE  = 34,
  parameter int unsigned W2_MUTE  = 18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic       in_rise,
  input  logic       in_fall,
  input  logic       dsd_evt,
  input  logic       pcm_evt,
  input  logic       sync_in,
  input  logic [1:0] pcm_mode,
  output logic       dsd_bit,
  output logic       dsd_valid,
  output logic       dsd_mute,
  output logic       pcm_bit,
  output logic       pcm_valid,
  output logic       pcm_mute
);

  localparam int unsigned NPATH   = 2;
  localparam int unsigned MAX_LEN = max3(BIT_MUTE, W8_MUTE, W2_MUTE);
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  logic buf_a, buf_b, second_half, sync_rise, phase_tick;
  logic [NPATH-1:0] evt_v;
  logic [NPATH-1:0] bit_v, valid_v, mute_v;

  assign evt_v = {pcm_evt, dsd_evt};

  dsdrs_capture u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .din         (din),
    .in_rise     (in_rise),
    .in_fall     (in_fall),
    .sync_in     (sync_in),
    .buf_a       (buf_a),
    .buf_b       (buf_b),
    .second_half (second_half),
    .sync_rise   (sync_rise),
    .phase_tick  (phase_tick)
  );

  for (genvar gi = 0; gi < NPATH; gi++) begin : g_path
    logic [1:0] path_mode;
    assign path_mode = (gi == 0) ? 2'(SPAN_BIT) : pcm_mode;

    dsdrs_path #(
      .BIT_LEN (BIT_MUTE),
      .W8_LEN  (W8_MUTE),
      .W2_LEN  (W2_MUTE),
      .CNT_W   (CNT_W)
    ) u_path (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt         (evt_v[gi]),
      .mode        (path_mode),
      .buf_a       (buf_a),
      .buf_b       (buf_b),
      .second_half (second_half),
      .sync_rise   (sync_rise),
      .phase_tick  (phase_tick),
      .out_bit     (bit_v[gi]),
      .out_valid   (valid_v[gi]),
      .out_mute    (mute_v[gi])
    );
  end

  assign dsd_bit   = bit_v[0];
  assign dsd_valid = valid_v[0];
  assign dsd_mute  = mute_v[0];
  assign pcm_bit   = bit_v[1];
  assign pcm_valid = valid_v[1];
  assign pcm_mute  = mute_v[1];

endmodule

// File: tb/dsd_resync_test.sv
module dsd_resync_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0, in_rise = 1'b0, in_fall = 1'b0;
  logic dsd_evt = 1'b0, pcm_evt = 1'b0, sync_in = 1'b0;
  logic [1:0] pcm_mode = 2'd1;
  logic dsd_bit, dsd_valid, dsd_mute, pcm_bit, pcm_valid, pcm_mute;

  always #2.5 clk = ~clk;

  dsd_resync uut (
    .clk(clk), .rst_n(rst_n), .din(din), .in_rise(in_rise), .in_fall(in_fall),
    .dsd_evt(dsd_evt), .pcm_evt(pcm_evt), .sync_in(sync_in), .pcm_mode(pcm_mode),
    .dsd_bit(dsd_bit), .dsd_valid(dsd_valid), .dsd_mute(dsd_mute),
    .pcm_bit(pcm_bit), .pcm_valid(pcm_valid), .pcm_mute(pcm_mute)
  );

  int compared = 0, mismatched = 0;
  bit finished = 0;

  // stimulus control
  int  cyc = 0;
  bit  gen_on = 0;
  int  dsd_base = 11, pcm_base = 13, dsd_off = 11, pcm_off = 13;
  int  sync_hold = 0;
  bit  din_r = 0, sync_prev = 0, second = 0, armed = 0;
  string mute_tag_dsd = "R5";

  // reference model (index 0 = DSD path, 1 = PCM path)
  bit hist[$];
  int  ratio [2] = '{1, 4};
  int  cnt_m [2] = '{0, 0};
  bit  idle_m[2] = '{0, 0};
  bit  pend_m[2] = '{0, 0};
  bit  lock_m[2] = '{0, 0};
  bit  ok_m  [2] = '{0, 0};
  bit  first_m[2] = '{0, 0};
  int  idx_m [2] = '{0, 0};
  bit  exp_valid[2] = '{0, 0};
  bit  exp_mute [2] = '{0, 0};
  bit  exp_bit  [2] = '{0, 0};
  bit  exp_known[2] = '{1, 1};
  string bit_tag[2] = '{"R10", "R10"};

  function automatic int mute_for(input int p, input logic [1:0] m);
    if (p == 0) return 4;
    if (m == 2'd1) return 34;
    if (m == 2'd2) return 18;
    return 4;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic step();
    bit rise, fall, sync_v, sync_edge;
    bit ev[2];
    bit ov[2], om[2], ob[2];
    @(negedge clk);
    ov = '{dsd_valid, pcm_valid};
    om = '{dsd_mute, pcm_mute};
    ob = '{dsd_bit, pcm_bit};
    for (int p = 0; p < 2; p++) begin
      chk(ov[p] == exp_valid[p], "R4", p == 0 ? "dsd_valid" : "pcm_valid", ov[p], exp_valid[p]);
      chk(om[p] == exp_mute[p], p == 0 ? mute_tag_dsd : "R6",
          p == 0 ? "dsd_mute" : "pcm_mute", om[p], exp_mute[p]);
      if (exp_known[p])
        chk(ob[p] == exp_bit[p], bit_tag[p], p == 0 ? "dsd_bit" : "pcm_bit", ob[p], exp_bit[p]);
    end

    rise = gen_on && (cyc % 16 == 0);
    fall = gen_on && (cyc % 16 == 8);
    if (rise) begin
      dsd_off = dsd_base + ($urandom % 3) * 2 - 2;
      pcm_off = pcm_base;
    end
    if (gen_on && (cyc % 16 == 9)) din_r = 1'($urandom % 2);
    ev[0] = gen_on && (cyc % 16 == dsd_off);
    ev[1] = gen_on && ((cyc / 16) % 4 == 0) && (cyc % 16 == pcm_off);
    sync_v = (sync_hold > 0);
    if (sync_hold > 0) sync_hold--;

    din = din_r; in_rise = rise; in_fall = fall;
    dsd_evt = ev[0]; pcm_evt = ev[1]; sync_in = sync_v;

    if (rise) hist.push_back(din_r);
    sync_edge = sync_v && !sync_prev;
    sync_prev = sync_v;
    if (sync_edge) begin
      armed = 1;
      for (int p = 0; p < 2; p++) begin
        cnt_m[p] = mute_for(p, pcm_mode);
        idle_m[p] = 0; pend_m[p] = 0; first_m[p] = 1;
      end
    end
    if (fall && armed) begin
      armed = 0;
      pend_m = '{1, 1};
    end
    for (int p = 0; p < 2; p++) begin
      exp_valid[p] = ev[p];
      if (ev[p]) begin
        if (pend_m[p]) begin
          pend_m[p] = 0; lock_m[p] = 1; ok_m[p] = 1;
          idx_m[p] = second ? hist.size() - 1 : hist.size() - 2;
        end else if (lock_m[p]) begin
          idx_m[p] += ratio[p];
        end
        if (cnt_m[p] > 0) begin
          exp_mute[p] = 1; exp_bit[p] = idle_m[p]; exp_known[p] = 1;
          bit_tag[p] = "R7";
          idle_m[p] ^= 1'b1; cnt_m[p]--;
        end else begin
          exp_mute[p] = 0;
          if (lock_m[p] && ok_m[p] && idx_m[p] >= 0 && idx_m[p] < hist.size()) begin
            exp_bit[p] = hist[idx_m[p]]; exp_known[p] = 1;
            if (first_m[p]) bit_tag[p] = "R2";
            else bit_tag[p] = (p == 0) ? "R3 (R1)" : "R9";
            first_m[p] = 0;
          end else begin
            exp_known[p] = 0;
          end
        end
      end
    end
    if (fall) second = 1;
    else if (rise) second = 0;
    cyc++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_sync(input int ph);
    while ((cyc % 16) != ph) step();
    sync_hold = 3;
    run(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R10: reset holds every output low
    run(4);
    chk(dsd_bit == 0 && pcm_bit == 0, "R10", "bits in reset", dsd_bit + pcm_bit, 0);
    chk(dsd_valid == 0 && pcm_valid == 0, "R10", "valids in reset", dsd_valid + pcm_valid, 0);
    chk(dsd_mute == 0 && pcm_mute == 0, "R10", "mutes in reset", dsd_mute + pcm_mute, 0);
    rst_n = 1'b1;
    gen_on = 1;

    // events late in the period, PCM 34-event mute (R2 R3 R5 R6 R7 R9)
    pcm_mode = 2'd1; dsd_base = 11; pcm_base = 13;
    run(40);
    do_sync(4);
    run(2400);

    // phase step to early in the period, PCM 18-event mute
    pcm_mode = 2'd2; dsd_base = 3; pcm_base = 5;
    ok_m = '{0, 0};
    run(40);
    do_sync(7);
    run(1400);

    // R8: second sync inside a running window
    pcm_mode = 2'd0; mute_tag_dsd = "R8";
    do_sync(7);
    run(32);
    do_sync(7);
    run(600);

    // reserved mode code falls back to the short window (R6)
    pcm_mode = 2'd3; mute_tag_dsd = "R5";
    do_sync(7);
    run(600);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule